// File: doc/BRIEF.md
# Bidirectional Barrel Shifter with Fill Bit

This block shifts a 32-bit data word left or right by 0 to 31 positions in a single combinational pass. The positions that the shift empties are filled with copies of a separate fill input. The caller picks the kind of shift through that fill input. For a logical shift it drives the fill with zero. For an arithmetic right shift it drives the fill with the top bit of the data. A fill of one gives ones-insertion, which is handy for building masks.

There is only one shift network, and it shifts left. A right shift mirrors the bit order of the word before that network and mirrors the result again after it, so both directions use the same hardware. The network is a barrel of log2(W) stages. Each stage moves the word by a fixed power of two, and one bit of the shift amount switches that stage in or out.

Top module: `bidir_fill_shifter`

## Requirements
- R1: With `dir_i` = 0 (left), `data_o` equals `data_i` shifted left by `amt_i`, and its lowest `amt_i` bits all equal `fill_i`.
- R2: With `dir_i` = 1 (right), `data_o` equals `data_i` shifted right by `amt_i`, and its highest `amt_i` bits all equal `fill_i`.
- R3: With `amt_i` = 0, `data_o` equals `data_i` in either direction, whatever the value of `fill_i`.
- R4: A right shift with `fill_i` tied to `data_i[31]` gives the signed arithmetic right shift of `data_i`.
- R5: A right shift with `fill_i` = 0 gives the unsigned logical right shift of `data_i`.
- R6: A left shift by 31 puts `data_i[0]` in bit 31 and sets every other bit to `fill_i`.
- R7: A right shift by 31 puts `data_i[31]` in bit 0 and sets every other bit to `fill_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Word to shift |
| amt_i | input | 5 | Shift distance, unsigned, 0 to 31 |
| fill_i | input | 1 | Value written into every vacated position |
| dir_i | input | 1 | 0 = shift left, 1 = shift right |
| data_o | output | 32 | Shifted word |

## Verification
Every shift distance is swept in both directions with the fill at 0 and at 1. The sweep uses three data words: an irregular mix, a word with only its two end bits set, and that word's complement. The irregular word shows whether a stage moves the wrong distance. The end-bit words show whether the mirroring is wrong or whether the fill leaks into positions that should hold data. Directed vectors cover distance 0 with fill 1 to confirm the fill is ignored, distance 31 in both directions, and right shifts of a negative word with the sign bit as fill and with zero fill.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shift_dir_e;

endpackage

// File: rtl/bshift_stage.sv
// One barrel stage: moves the word left by DIST when en is high and
// pushes the fill value into the positions it empties.
module bshift_stage #(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic [W-1:0] d_i,
  input  logic         fill_i,
  input  logic         en_i,
  output logic [W-1:0] d_o
);

  logic [W-1:0] moved;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= DIST) begin : g_take
      assign moved[i] = d_i[i-DIST];
    end else begin : g_fill
      assign moved[i] = fill_i;
    end
  end

  assign d_o = en_i ? moved : d_i;

endmodule

// File: rtl/bshift_mirror.sv
// Reverses bit order; pure wiring.
module bshift_mirror #(
  parameter int W = 32
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign d_o[i] = d_i[W-1-i];
  end

endmodule

// File: rtl/bshift_left_core.sv
// Log-depth left shifter: stage s moves by 2**s under control of amt_i[s].
module bshift_left_core #(
  parameter int W   = 32,
  parameter int SAW = $clog2(W)
) (
  input  logic [W-1:0]   d_i,
  input  logic [SAW-1:0] amt_i,
  input  logic           fill_i,
  output logic [W-1:0]   d_o
);

  logic [W-1:0] lvl [SAW+1];

  assign lvl[0] = d_i;

  for (genvar s = 0; s < SAW; s++) begin : g_stage
    bshift_stage #(
      .W    (W),
      .DIST (1 << s)
    ) stage_i (
      .d_i    (lvl[s]),
      .fill_i (fill_i),
      .en_i   (amt_i[s]),
      .d_o    (lvl[s+1])
    );
  end

  assign d_o = lvl[SAW];

endmodule

// File: rtl/bidir_fill_shifter.sv
module bidir_fill_shifter
  import bshift_pkg::*;
#(
  parameter int W   = 32,
  parameter int SAW = $clog2(W)
) (
  input  logic [W-1:0]   data_i,
  input  logic [SAW-1:0] amt_i,
  input  logic           fill_i,
  input  logic           dir_i,
  output logic [W-1:0]   data_o
);

  shift_dir_e   dir;
  logic [W-1:0] data_rev;
  logic [W-1:0] core_in;
  logic [W-1:0] core_out;
  logic [W-1:0] core_rev;

  assign dir = shift_dir_e'(dir_i);

  bshift_mirror #(.W(W)) mirror_in_i (
    .d_i (data_i),
    .d_o (data_rev)
  );

  assign core_in = (dir == DIR_RIGHT) ? data_rev : data_i;

  bshift_left_core #(.W(W), .SAW(SAW)) core_i (
    .d_i    (core_in),
    .amt_i  (amt_i),
    .fill_i (fill_i),
    .d_o    (core_out)
  );

  bshift_mirror #(.W(W)) mirror_out_i (
    .d_i (core_out),
    .d_o (core_rev)
  );

  assign data_o = (dir == DIR_RIGHT) ? core_rev : core_out;

endmodule

// File: rtl/bidir_fill_shifter_chk.sv
module bidir_fill_shifter_chk #(
  parameter int W   = 32,
  parameter int SAW = $clog2(W)
) (
  input logic [W-1:0]   data_i,
  input logic [SAW-1:0] amt_i,
  input logic           fill_i,
  input logic           dir_i,
  input logic [W-1:0]   data_o
);

  logic [W-1:0] lo_mask;
  logic [W-1:0] hi_mask;

  always_comb begin
    lo_mask = ~({W{1'b1}} << amt_i);
    hi_mask = ~({W{1'b1}} >> amt_i);

    if (!dir_i) begin
      p_left_fill_r1: assert ((data_o & lo_mask) == (fill_i ? lo_mask : '0))
        else $error("left fill bits wrong");
      p_left_body_r1: assert ((data_o & ~lo_mask) == (data_i << amt_i))
        else $error("left data bits wrong");
    end else begin
      p_right_fill_r2: assert ((data_o & hi_mask) == (fill_i ? hi_mask : '0))
        else $error("right fill bits wrong");
      p_right_body_r2: assert ((data_o & ~hi_mask) == (data_i >> amt_i))
        else $error("right data bits wrong");
    end

    if (amt_i == '0) begin
      p_zero_pass_r3: assert (data_o == data_i)
        else $error("zero distance altered data");
    end

    if (!dir_i && amt_i == SAW'(W-1)) begin
      p_left_max_r6: assert (data_o[W-1] == data_i[0])
        else $error("max left shift top bit wrong");
    end

    if (dir_i && amt_i == SAW'(W-1)) begin
      p_right_max_r7: assert (data_o[0] == data_i[W-1])
        else $error("max right shift low bit wrong");
    end
  end

endmodule

bind bidir_fill_shifter bidir_fill_shifter_chk #(.W(W), .SAW(SAW)) chk_i (
  .data_i (data_i),
  .amt_i  (amt_i),
  .fill_i (fill_i),
  .dir_i  (dir_i),
  .data_o (data_o)
);

// File: tb/bidir_fill_shifter_tb_top.sv
module bidir_fill_shifter_tb_top;

  localparam int W   = 32;
  localparam int SAW = 5;
  localparam int NV  = 15;

  typedef struct packed {
    logic [W-1:0]   b;
    logic [SAW-1:0] sa;
    logic           fill;
    logic           dir;
    logic [W-1:0]   exp;
    logic [7:0]     req;
  } vec_t;

  // Expected results worked out by hand from the requirements.
  localparam vec_t TBL [NV] = '{
    '{32'h8000_0001, 5'd1,  1'b0, 1'b0, 32'h0000_0002, 8'd1},
    '{32'h8000_0001, 5'd1,  1'b1, 1'b0, 32'h0000_0003, 8'd1},
    '{32'h8000_0001, 5'd1,  1'b0, 1'b1, 32'h4000_0000, 8'd2},
    '{32'h8000_0001, 5'd1,  1'b1, 1'b1, 32'hC000_0000, 8'd4},
    '{32'h1234_5678, 5'd0,  1'b1, 1'b0, 32'h1234_5678, 8'd3},
    '{32'h1234_5678, 5'd0,  1'b1, 1'b1, 32'h1234_5678, 8'd3},
    '{32'h0000_0001, 5'd31, 1'b0, 1'b0, 32'h8000_0000, 8'd6},
    '{32'h0000_0001, 5'd31, 1'b1, 1'b0, 32'hFFFF_FFFF, 8'd6},
    '{32'h8000_0000, 5'd31, 1'b0, 1'b1, 32'h0000_0001, 8'd7},
    '{32'h7FFF_FFFF, 5'd31, 1'b1, 1'b1, 32'hFFFF_FFFE, 8'd7},
    '{32'hF000_0000, 5'd4,  1'b1, 1'b1, 32'hFF00_0000, 8'd4},
    '{32'hF000_0000, 5'd4,  1'b0, 1'b1, 32'h0F00_0000, 8'd5},
    '{32'h0000_ABCD, 5'd16, 1'b0, 1'b0, 32'hABCD_0000, 8'd1},
    '{32'hABCD_0000, 5'd16, 1'b0, 1'b1, 32'h0000_ABCD, 8'd5},
    '{32'h0000_0000, 5'd8,  1'b1, 1'b0, 32'h0000_00FF, 8'd1}
  };

  logic           clk;
  logic [W-1:0]   data_i;
  logic [SAW-1:0] amt_i;
  logic           fill_i;
  logic           dir_i;
  logic [W-1:0]   data_o;

  int n_checks;
  int n_fail;
  bit done;

  bidir_fill_shifter #(.W(W), .SAW(SAW)) dut_i (
    .data_i (data_i),
    .amt_i  (amt_i),
    .fill_i (fill_i),
    .dir_i  (dir_i),
    .data_o (data_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W-1:0] model(input logic [W-1:0] b, input int sa,
                                         input logic fill, input logic dir);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int src;
      src = dir ? i + sa : i - sa;
      r[i] = (src >= 0 && src < W) ? b[src] : fill;
    end
    return r;
  endfunction

  task automatic apply(input logic [W-1:0] b, input int sa, input logic fill,
                       input logic dir);
    @(negedge clk);
    data_i = b;
    amt_i  = SAW'(sa);
    fill_i = fill;
    dir_i  = dir;
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    n_checks++;
    if (data_o !== exp) begin
      n_fail++;
      $display("FAIL %s: data_i=%h amt=%0d fill=%b dir=%b actual=%h expected=%h",
               req, data_i, amt_i, fill_i, dir_i, data_o, exp);
    end
  endtask

  initial begin
    logic [W-1:0] pats [3];
    pats[0] = 32'hA5C3_0F96;
    pats[1] = 32'h8000_0001;
    pats[2] = 32'h7FFF_FFFE;
    n_checks = 0;
    n_fail   = 0;
    data_i = '0; amt_i = '0; fill_i = 1'b0; dir_i = 1'b0;

    // Idle state: all-zero inputs give zero (R3 pass-through of zero).
    apply('0, 0, 1'b0, 1'b0);
    check("R3", '0);

    // Vector table.
    for (int k = 0; k < NV; k++) begin
      apply(TBL[k].b, int'(TBL[k].sa), TBL[k].fill, TBL[k].dir);
      check($sformatf("R%0d", TBL[k].req), TBL[k].exp);
    end

    // Full sweep: R1 (left) and R2 (right), each fill value.
    for (int p = 0; p < 3; p++) begin
      for (int sa = 0; sa < W; sa++) begin
        for (int d = 0; d < 2; d++) begin
          for (int f = 0; f < 2; f++) begin
            apply(pats[p], sa, f[0], d[0]);
            check(d ? "R2" : "R1", model(pats[p], sa, f[0], d[0]));
          end
        end
      end
    end

    // R4 / R5: right shifts against the language operators.
    for (int sa = 0; sa < W; sa += 3) begin
      apply(32'h9A3C_0F81, sa, 1'b1, 1'b1);
      check("R4", W'($signed(32'h9A3C_0F81) >>> sa));
      apply(32'h9A3C_0F81, sa, 1'b0, 1'b1);
      check("R5", 32'h9A3C_0F81 >> sa);
    end

    done = 1'b1;
  end

  initial begin
    done = 1'b0;
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule